// File: doc/BRIEF.md
# Pipelined Store Bus Master with Outstanding-Acknowledge Tracking

This block drives a pipelined, stall-capable bus for data-cache stores. It takes store requests (address, write data, byte enables) from a store queue, one per handshake. It places a single store or a back-to-back run of stores on the bus, and keeps a running count of stores that have been issued but not yet acknowledged. A store queue feeds it through a valid/take handshake. The slave throttles it with a stall input and retires stores with an acknowledge input.

The outstanding count is maintained in every cycle, whatever the controller is doing. It is driven only by the bus strobe and by one-cycle-delayed copies of the slave's stall and acknowledge. An issue and an acknowledge that land in the same cycle therefore cancel. The controller ends the bus cycle when the strobe is already low and the acknowledge for the last outstanding store arrives. A further store is only issued while the count leaves room, so the counter never wraps.

Top module: `store_ack_tracker`

## Requirements
- R1: After a synchronous active-low reset, bus_cyc_o, bus_stb_o, bus_we_o, store_done_o and pend_cnt_o are all zero, and req_take_o stays low while req_valid_i is low.
- R2: While bus_cyc_o is low, a high req_valid_i raises req_take_o in the same cycle. In the next cycle bus_cyc_o, bus_stb_o and bus_we_o are high and bus_adr_o, bus_dat_o and bus_sel_o carry that request's fields.
- R3: When bus_stb_o and bus_stall_i are both high, bus_stb_o stays high in the next cycle with address, data and byte enables unchanged, and req_take_o stays low.
- R4: When bus_stb_o is high and bus_stall_i is low, a high req_valid_i together with pend_cnt_o below 6 raises req_take_o in that cycle, and the taken request is presented in the next cycle with bus_stb_o still high. Otherwise bus_stb_o is low in the next cycle.
- R5: Stall and acknowledge are registered every cycle, each gated by bus_cyc_o. In the next cycle pend_cnt_o becomes zero if bus_cyc_o is low. Otherwise it rises by one when bus_stb_o is high and neither registered flag is set. It falls by one when the registered acknowledge is set and either bus_stb_o is low or the registered stall is set. In every other case it holds. As a result, pend_cnt_o equals the stores issued so far in the bus cycle minus the acknowledges received up to two cycles back.
- R6: pend_cnt_o is 3 bits wide, reaches 7 when seven stores are issued without acknowledge, and never wraps.
- R7: bus_cyc_o falls exactly one cycle after an acknowledge that arrives while bus_stb_o is low and no other issued store is unacknowledged, and at no other time.
- R8: store_done_o is high for one cycle in the cycle after each bus_ack_i sampled while bus_cyc_o is high.
- R9: While bus_cyc_o is high and bus_stb_o is low, req_take_o stays low.
- R10: bus_stb_o is never high without bus_cyc_o, and bus_we_o always equals bus_cyc_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Store queue has a request |
| req_addr_i | input | ADDR_W | Store address |
| req_data_i | input | DATA_W | Store write data |
| req_sel_i | input | SEL_W | Store byte enables |
| req_take_o | output | 1 | Request consumed this cycle |
| bus_cyc_o | output | 1 | Bus cycle active |
| bus_stb_o | output | 1 | Bus strobe |
| bus_we_o | output | 1 | Write enable |
| bus_adr_o | output | ADDR_W | Bus address |
| bus_dat_o | output | DATA_W | Bus write data |
| bus_sel_o | output | SEL_W | Bus byte enables |
| bus_stall_i | input | 1 | Slave stall |
| bus_ack_i | input | 1 | Slave acknowledge |
| store_done_o | output | 1 | One-cycle pulse per acknowledged store |
| pend_cnt_o | output | CNT_W | Issued-but-unacknowledged store count |

## Verification
req_take_o is combinational and is due in the same cycle as the inputs that cause it. The bus outputs, store_done_o and the bus-cycle end are due one clock after their cause. The count reflects a strobe one clock later and an acknowledge two clocks later. The bench drives inputs at the falling edge and compares every output against a behavioural model at the next falling edge, with req_take_o checked one time unit after the inputs change. The model counts issued strobes and received acknowledges as plain integers and applies these latencies, while a slave model injects random stall, acknowledge delays and an acknowledge hold-off.

// File: rtl/sat_pkg.sv
// Package: shared types for the store acknowledge tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package sat_pkg;

    typedef enum logic {
        SAT_IDLE,
        SAT_BUSY
    } sat_state_e;

endpackage

// File: rtl/sat_ack_counter.sv
// Module: sat_ack_counter
// Keeps the count of issued-but-unacknowledged stores, updated every cycle
// from the strobe and one-cycle-delayed copies of stall and acknowledge.
// Assumes the slave never acknowledges in the cycle a strobe is accepted.
module sat_ack_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_i,
    input  logic             stb_i,
    input  logic             stall_i,
    input  logic             ack_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] outst_o,
    output logic             ack_seen_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             stall_q;
    logic             ack_q;

    // Next count: clear outside a bus cycle, else issue/acknowledge arithmetic.
    always_comb begin
        if (!cyc_i) begin
            cnt_nxt = '0;
        end else if (stb_i && !stall_q && !ack_q) begin
            cnt_nxt = cnt_q + CNT_ONE;
        end else if (ack_q && (!stb_i || stall_q)) begin
            cnt_nxt = cnt_q - CNT_ONE;
        end else begin
            cnt_nxt = cnt_q;
        end
    end

    // Register the gated slave flags and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
            ack_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            stall_q <= stall_i && cyc_i;
            ack_q   <= ack_i && cyc_i;
            cnt_q   <= cnt_nxt;
        end
    end

    assign cnt_o      = cnt_q;
    assign outst_o    = cnt_q - (ack_q ? CNT_ONE : '0);
    assign ack_seen_o = ack_q;

    AST_CLR_OUTSIDE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_i |=> cnt_q == '0); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && cnt_q == CNT_MAX) |=> cnt_q >= CNT_MAX - CNT_ONE); // R6

    AST_DONE_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && cyc_i) |=> ack_q); // R8

endmodule

// File: rtl/sat_store_issuer.sv
// Module: sat_store_issuer
// Bus-side controller: opens a bus cycle for a queued store, chains further
// stores while the slave accepts and the count has room, and closes the
// cycle on the acknowledge of the last outstanding store.
// Assumes cnt_i/outst_i come from sat_ack_counter in the same clock domain.
module sat_store_issuer
    import sat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SEL_W  = DATA_W / 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_data_i,
    input  logic [SEL_W-1:0]  req_sel_i,
    output logic              req_take_o,
    input  logic              bus_stall_i,
    input  logic              bus_ack_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  outst_i,
    output logic              cyc_o,
    output logic              stb_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] adr_o,
    output logic [DATA_W-1:0] dat_o,
    output logic [SEL_W-1:0]  sel_o
);
    localparam int               CNT_TOP = (1 << CNT_W) - 1;
    localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(CNT_TOP - 1);
    localparam logic [CNT_W-1:0] LAST_ONE = CNT_W'(1);

    sat_state_e        state_q;
    logic              cyc_q;
    logic              stb_q;
    logic              we_q;
    logic [ADDR_W-1:0] adr_q;
    logic [DATA_W-1:0] dat_q;
    logic [SEL_W-1:0]  sel_q;

    logic accepted;
    logic has_room;
    logic take_open;
    logic take_chain;
    logic last_ack;

    // Handshake and end-of-cycle decisions for the current cycle.
    always_comb begin
        accepted   = stb_q && !bus_stall_i;
        has_room   = cnt_i < ROOM_LIMIT;
        take_open  = (state_q == SAT_IDLE) && req_valid_i;
        take_chain = (state_q == SAT_BUSY) && accepted && req_valid_i && has_room;
        last_ack   = (state_q == SAT_BUSY) && !stb_q && bus_ack_i && (outst_i == LAST_ONE);
    end

    assign req_take_o = take_open || take_chain;

    // Control state: bus cycle, strobe and write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SAT_IDLE;
            cyc_q   <= 1'b0;
            stb_q   <= 1'b0;
            we_q    <= 1'b0;
        end else begin
            case (state_q)
                SAT_IDLE: begin
                    if (req_valid_i) begin
                        state_q <= SAT_BUSY;
                        cyc_q   <= 1'b1;
                        stb_q   <= 1'b1;
                        we_q    <= 1'b1;
                    end
                end
                SAT_BUSY: begin
                    if (accepted && !take_chain) begin
                        stb_q <= 1'b0;
                    end
                    if (last_ack) begin
                        state_q <= SAT_IDLE;
                        cyc_q   <= 1'b0;
                        we_q    <= 1'b0;
                    end
                end
                default: state_q <= SAT_IDLE;
            endcase
        end
    end

    // Payload registers: load whenever a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q <= '0;
            dat_q <= '0;
            sel_q <= '0;
        end else if (req_take_o) begin
            adr_q <= req_addr_i;
            dat_q <= req_data_i;
            sel_q <= req_sel_i;
        end
    end

    assign cyc_o = cyc_q;
    assign stb_o = stb_q;
    assign we_o  = we_q;
    assign adr_o = adr_q;
    assign dat_o = dat_q;
    assign sel_o = sel_q;

    AST_STALL_HOLDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q && bus_stall_i) |=> (stb_q && $stable(adr_q) && $stable(dat_q) && $stable(sel_q))); // R3

    AST_STB_INSIDE_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> (cyc_q && we_q)); // R10

    AST_CYC_ENDS_ON_LAST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cyc_q) |-> $past(bus_ack_i && !stb_q)); // R7

    AST_CHAIN_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_take_o && cyc_q) |-> (cnt_i < ROOM_LIMIT)); // R4

    AST_NO_TAKE_WHILE_DRAINING: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q && !stb_q) |-> !req_take_o); // R9

endmodule

// File: rtl/store_ack_tracker.sv
// Module: store_ack_tracker (top)
// Pipelined store bus master with an outstanding-acknowledge counter.
// Assumes a slave that acknowledges stores in order, at least one cycle
// after accepting each strobe, and only while the bus cycle is open.
module store_ack_tracker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SEL_W  = DATA_W / 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_data_i,
    input  logic [SEL_W-1:0]  req_sel_i,
    output logic              req_take_o,
    output logic              bus_cyc_o,
    output logic              bus_stb_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_adr_o,
    output logic [DATA_W-1:0] bus_dat_o,
    output logic [SEL_W-1:0]  bus_sel_o,
    input  logic              bus_stall_i,
    input  logic              bus_ack_i,
    output logic              store_done_o,
    output logic [CNT_W-1:0]  pend_cnt_o
);
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] outst_w;
    logic             ack_seen_w;

    sat_store_issuer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .CNT_W  (CNT_W)
    ) u_issuer (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_addr_i  (req_addr_i),
        .req_data_i  (req_data_i),
        .req_sel_i   (req_sel_i),
        .req_take_o  (req_take_o),
        .bus_stall_i (bus_stall_i),
        .bus_ack_i   (bus_ack_i),
        .cnt_i       (cnt_w),
        .outst_i     (outst_w),
        .cyc_o       (bus_cyc_o),
        .stb_o       (bus_stb_o),
        .we_o        (bus_we_o),
        .adr_o       (bus_adr_o),
        .dat_o       (bus_dat_o),
        .sel_o       (bus_sel_o)
    );

    sat_ack_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_i      (bus_cyc_o),
        .stb_i      (bus_stb_o),
        .stall_i    (bus_stall_i),
        .ack_i      (bus_ack_i),
        .cnt_o      (cnt_w),
        .outst_o    (outst_w),
        .ack_seen_o (ack_seen_w)
    );

    assign pend_cnt_o   = cnt_w;
    assign store_done_o = ack_seen_w;

endmodule

// File: tb/tb_store_ack_tracker.sv
module tb_store_ack_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int SW = DW / 8;
    localparam int CW = 3;
    localparam int QN = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [DW-1:0] req_data_i = '0;
    logic [SW-1:0] req_sel_i = '0;
    logic          req_take_o;
    logic          bus_cyc_o, bus_stb_o, bus_we_o;
    logic [AW-1:0] bus_adr_o;
    logic [DW-1:0] bus_dat_o;
    logic [SW-1:0] bus_sel_o;
    logic          bus_stall_i = 1'b0;
    logic          bus_ack_i = 1'b0;
    logic          store_done_o;
    logic [CW-1:0] pend_cnt_o;

    store_ack_tracker #(.ADDR_W(AW), .DATA_W(DW), .SEL_W(SW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
        .req_data_i(req_data_i), .req_sel_i(req_sel_i), .req_take_o(req_take_o),
        .bus_cyc_o(bus_cyc_o), .bus_stb_o(bus_stb_o), .bus_we_o(bus_we_o),
        .bus_adr_o(bus_adr_o), .bus_dat_o(bus_dat_o), .bus_sel_o(bus_sel_o),
        .bus_stall_i(bus_stall_i), .bus_ack_i(bus_ack_i),
        .store_done_o(store_done_o), .pend_cnt_o(pend_cnt_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Store queue contents and pointers.
    logic [AW-1:0] q_addr [QN];
    logic [DW-1:0] q_data [QN];
    logic [SW-1:0] q_sel  [QN];
    int q_head = 0;
    int q_tail = 0;

    // Slave model: ready cycle of each accepted, unacknowledged store.
    int sl_ready [1024];
    int sl_h = 0;
    int sl_t = 0;
    int cyc_no = 0;

    // Scenario knobs.
    int stall_pct = 0;
    int req_pct = 100;
    int ack_pct = 100;
    int dly_max = 1;
    bit ack_hold = 1'b0;

    // Reference model state.
    bit            exp_cyc = 0, exp_stb = 0, exp_done = 0, exp_take = 0;
    int            exp_cnt = 0;
    logic [AW-1:0] exp_adr = '0;
    logic [DW-1:0] exp_dat = '0;
    logic [SW-1:0] exp_sel = '0;
    string         stb_tag = "R2";
    bit            prev_stb = 0, prev_stall = 0;
    int            iss = 0, ackc = 0;
    int            max_cnt = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One clock of stimulus, checking and model update.
    task automatic step();
        bit rv, st, ak, take, last, new_s;
        @(negedge clk);
        check(bus_cyc_o == exp_cyc, "R7", "bus_cyc_o", bus_cyc_o, exp_cyc);
        check(bus_stb_o == exp_stb, stb_tag, "bus_stb_o", bus_stb_o, exp_stb);
        check(bus_we_o == exp_cyc, "R10", "bus_we_o", bus_we_o, exp_cyc);
        check(store_done_o == exp_done, "R8", "store_done_o", store_done_o, exp_done);
        check(int'(pend_cnt_o) == exp_cnt, (exp_cnt >= 6) ? "R6" : "R5",
              "pend_cnt_o", pend_cnt_o, exp_cnt);
        if (int'(pend_cnt_o) > max_cnt) max_cnt = int'(pend_cnt_o);
        if (exp_stb) begin
            check(bus_adr_o == exp_adr, stb_tag, "bus_adr_o", bus_adr_o, exp_adr);
            check(bus_dat_o == exp_dat, stb_tag, "bus_dat_o", bus_dat_o, exp_dat);
            check(bus_sel_o == exp_sel, stb_tag, "bus_sel_o", bus_sel_o, exp_sel);
        end

        rv = (q_head < q_tail) && (($urandom % 100) < req_pct);
        st = (($urandom % 100) < stall_pct);
        ak = !ack_hold && (sl_h < sl_t) && (sl_ready[sl_h] <= cyc_no)
             && (($urandom % 100) < ack_pct);
        req_valid_i = rv;
        req_addr_i  = rv ? q_addr[q_head] : '0;
        req_data_i  = rv ? q_data[q_head] : '0;
        req_sel_i   = rv ? q_sel[q_head] : '0;
        bus_stall_i = st;
        bus_ack_i   = ak;
        #1;

        if (!exp_cyc) take = rv;
        else take = exp_stb && !st && rv && (exp_cnt < 6);
        check(req_take_o == take,
              !exp_cyc ? "R2" : (!exp_stb ? "R9" : (st ? "R3" : "R4")),
              "req_take_o", req_take_o, take);

        // Slave bookkeeping.
        if (exp_stb && !st) begin
            sl_ready[sl_t] = cyc_no + 1 + int'($urandom % dly_max);
            sl_t++;
        end
        if (ak) sl_h++;

        // Model: next-cycle expectations.
        if (exp_cyc) begin
            new_s = exp_stb && !(prev_stb && prev_stall);
            if (new_s) iss++;
            exp_cnt = iss - ackc;
            if (ak) ackc++;
            exp_done = ak;
            last = ak && !exp_stb && (iss - ackc == 0);
            prev_stb = exp_stb;
            prev_stall = st;
            if (exp_stb) begin
                stb_tag = st ? "R3" : "R4";
                exp_stb = st ? 1'b1 : take;
            end else begin
                stb_tag = "R4";
            end
            if (last) exp_cyc = 0;
        end else begin
            iss = 0;
            ackc = 0;
            exp_cnt = 0;
            exp_done = 0;
            prev_stb = 0;
            prev_stall = 0;
            exp_cyc = rv;
            exp_stb = rv;
            stb_tag = "R2";
        end
        if (take) begin
            exp_adr = q_addr[q_head];
            exp_dat = q_data[q_head];
            exp_sel = q_sel[q_head];
            q_head++;
        end
        cyc_no++;
    endtask

    task automatic run_until_idle(input int limit);
        for (int n = 0; n < limit && (q_head < q_tail || exp_cyc); n++) step();
        for (int n = 0; n < 3; n++) step();
    endtask

    initial begin
        for (int i = 0; i < QN; i++) begin
            q_addr[i] = AW'(32'h0000_4000 + i * 8);
            q_data[i] = {32'(i * 32'h0101_0101), ~32'(i)};
            q_sel[i]  = SW'(i * 37 + 1);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state with no request pending.
        check(!bus_cyc_o && !bus_stb_o && !bus_we_o, "R1", "bus ctrl after reset",
              {bus_cyc_o, bus_stb_o, bus_we_o}, 0);
        check(!store_done_o && pend_cnt_o == '0, "R1", "done/count after reset",
              {store_done_o, pend_cnt_o}, 0);
        check(!req_take_o, "R1", "req_take_o idle", req_take_o, 0);

        // Single store, no stall, prompt ack (R2, R7).
        q_tail = 1; stall_pct = 0; req_pct = 100; ack_pct = 100; dly_max = 1;
        run_until_idle(50);

        // Short burst with stalls and varied ack delay (R3, R4).
        q_tail += 6; stall_pct = 50; dly_max = 3;
        run_until_idle(400);

        // Acks withheld: count must climb to 7 and stop (R6).
        q_tail += 12; stall_pct = 0; ack_hold = 1'b1; max_cnt = 0;
        for (int n = 0; n < 20; n++) step();
        check(max_cnt == 7, "R6", "peak pend_cnt_o", max_cnt, 7);
        ack_hold = 1'b0;
        run_until_idle(600);

        // Long random traffic (R5, R7, R8, R9).
        q_tail += 300; stall_pct = 30; req_pct = 70; ack_pct = 70; dly_max = 4;
        run_until_idle(20000);
        check(q_head == q_tail, "R4", "stores consumed", q_head, q_tail);

        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc_no, 0);
        finish_run();
    end

endmodule